// File: doc/BRIEF.md
# Push-Button Interrupt Flag Latch

This block watches a small group of push buttons and turns each press into a latched, active-low interrupt flag. A press is recognised on the falling edge of the button level once it has passed through a reset-safe synchronizer. The latched flag stays pending until the host clears it. A single active-low interrupt line goes to the host and is held low for as long as any flag is pending.

The host reads a status byte. Its upper half holds one flag per button, with button 0 in the lowest of those bits, and its lower half always reads zero. To acknowledge a button, the host writes a 1 to that button's bit in a clear register, then writes 0 to release it. Clearing is edge-based, so a button that is still held after its clear does not raise its flag again. While a clear bit stays at 1, presses on that button are not latched.

Top module: `pbirq_latch`

## Requirements
- R1: During and after reset, every flag reads 1, `status` equals 8'hF0 and `irq_n` is 1.
- R2: A 1-to-0 transition on `btn_n[i]` sets flag i to 0 in `status[4+i]`, visible at the third rising clock edge after the input change. A 0-to-1 transition sets no flag.
- R3: A button held low after its flag has been cleared does not set the flag again. Only a new 1-to-0 transition does.
- R4: A cycle with `clr_wr_en`=1 and `clr_wr_data[i]`=1 stores the clear bit. Flag i then reads 1 at the second rising edge after the strobe. Writing 0 releases the clear bit.
- R5: While clear bit i holds 1, a press on button i is ignored, even if the press is detected in the same cycle that the clear applies. Presses on the other buttons still latch.
- R6: `irq_n` is 0 whenever at least one flag is 0, and it is 1 only when all flags are 1. It returns to 1 only as the result of a clear.
- R7: Flags latch independently. A second press while another flag is pending latches its own flag, and `irq_n` stays low until every pending flag is cleared.
- R8: Bits [3:0] of `status` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| btn_n | input | NUM_BTN | Raw button levels, active low (pressed = 0), asynchronous |
| clr_wr_en | input | 1 | Write strobe for the clear register |
| clr_wr_data | input | NUM_BTN | Clear bits, one per button (status bit 4+i maps to index i) |
| status | output | 2*NUM_BTN | Flag register: flags in upper half (active low), lower half 0 |
| irq_n | output | 1 | Shared interrupt to the host, active low |

## Verification
Press detection and a held clear can act on the same button in the same cycle. The bench provokes this in two ways. It toggles a button while its clear bit is held at 1, and it presses two buttons at once while only one of them has its clear held. The held button's flag must stay at 1, and the other button's flag must latch. A clear on one flag can also coincide with a pending flag on another button. There, the interrupt line must stay low until the last pending flag is released.

// File: rtl/pbirq_pkg.sv
// Package: shared defaults for the push-button interrupt latch.
// Assumes: flags occupy the upper half of a status word twice the button count wide.
package pbirq_pkg;
    localparam int unsigned DEF_NUM_BTN     = 4;
    localparam int unsigned DEF_SYNC_STAGES = 2;
    localparam logic        BTN_IDLE        = 1'b1;  // released level of an active-low button
endpackage

// File: rtl/pbirq_sync.sv
// Module: pbirq_sync
// Multi-stage synchronizer for asynchronous active-low levels.
// Assumes: inputs idle high; reset loads the idle level so no false edge appears.
module pbirq_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain [STAGES];

    // Purpose: shift the raw level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= {WIDTH{pbirq_pkg::BTN_IDLE}};
        end else begin
            chain[0] <= async_in;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/pbirq_clear_reg.sv
// Module: pbirq_clear_reg
// Host-written clear register; each bit stays set until the host writes it back to 0.
// Assumes: a write replaces all bits at once.
module pbirq_clear_reg #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] clr_q
);
    // Purpose: capture the clear bits on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     clr_q <= '0;
        else if (wr_en) clr_q <= wr_data;
    end
endmodule

// File: rtl/pbirq_flag_cell.sv
// Module: pbirq_flag_cell
// One button: detects the falling edge of the synchronized level and latches an active-low flag.
// Assumes: a held clear beats a press detected in the same cycle.
module pbirq_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_n,
    input  logic clr,
    output logic flag_n
);
    logic prev_n;
    logic fall;

    assign fall = prev_n & ~sync_n;

    // Purpose: remember the last synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_n <= pbirq_pkg::BTN_IDLE;
        else        prev_n <= sync_n;
    end

    // Purpose: set the flag on a press, release it on a clear (clear wins).
    always_ff @(posedge clk) begin
        if (!rst_n)    flag_n <= 1'b1;
        else if (clr)  flag_n <= 1'b1;
        else if (fall) flag_n <= 1'b0;
    end
endmodule

// File: rtl/pbirq_latch.sv
// Module: pbirq_latch (top)
// Latches per-button interrupt flags, exposes them in a status word and drives a shared
// active-low interrupt line.
// Assumes: the host sets a clear bit and then releases it; buttons are raw asynchronous levels.
module pbirq_latch #(
    parameter int unsigned NUM_BTN     = pbirq_pkg::DEF_NUM_BTN,
    parameter int unsigned SYNC_STAGES = pbirq_pkg::DEF_SYNC_STAGES,
    localparam int unsigned REG_W      = 2 * NUM_BTN
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_BTN-1:0] btn_n,
    input  logic               clr_wr_en,
    input  logic [NUM_BTN-1:0] clr_wr_data,
    output logic [REG_W-1:0]   status,
    output logic               irq_n
);
    logic [NUM_BTN-1:0] btn_sync_n;
    logic [NUM_BTN-1:0] clr_hold;
    logic [NUM_BTN-1:0] flag_n;

    pbirq_sync #(.WIDTH(NUM_BTN), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (btn_n),
        .sync_out (btn_sync_n)
    );

    pbirq_clear_reg #(.WIDTH(NUM_BTN)) u_clr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (clr_wr_en),
        .wr_data (clr_wr_data),
        .clr_q   (clr_hold)
    );

    for (genvar i = 0; i < NUM_BTN; i++) begin : g_cell
        pbirq_flag_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .sync_n (btn_sync_n[i]),
            .clr    (clr_hold[i]),
            .flag_n (flag_n[i])
        );
    end

    // Purpose: flags in the upper half, lower half reads zero.
    assign status = {flag_n, {NUM_BTN{1'b0}}};
    // Purpose: interrupt low while any flag is pending.
    assign irq_n  = &flag_n;
endmodule

// File: rtl/pbirq_latch_chk.sv
// Module: pbirq_latch_chk
// Assertion checker bound to pbirq_latch; watches the flags, the clear bits and the interrupt line.
module pbirq_latch_chk #(
    parameter int unsigned NUM_BTN = 4,
    localparam int unsigned REG_W  = 2 * NUM_BTN
) (
    input logic               clk,
    input logic               rst_n,
    input logic [REG_W-1:0]   status,
    input logic               irq_n,
    input logic [NUM_BTN-1:0] clr_hold
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (status == {{NUM_BTN{1'b1}}, {NUM_BTN{1'b0}}}) && irq_n);

    // R6
    irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_n) |-> $past(|clr_hold));

    for (genvar i = 0; i < NUM_BTN; i++) begin : g_bit
        // R5
        no_set_under_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(status[NUM_BTN+i]) |-> !$past(clr_hold[i]));

        // R4
        clear_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(clr_hold[i]) |-> status[NUM_BTN+i]);
    end
endmodule

bind pbirq_latch pbirq_latch_chk #(.NUM_BTN(NUM_BTN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .status   (status),
    .irq_n    (irq_n),
    .clr_hold (clr_hold)
);

// File: tb/pbirq_latch_tb.sv
module pbirq_latch_tb;
    localparam int NB = 4;

    typedef struct {
        string      tag;
        logic [7:0] st;
        logic       irq;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB-1:0] btn_n = '1;
    logic          clr_wr_en = 1'b0;
    logic [NB-1:0] clr_wr_data = '0;
    logic [7:0]    status;
    logic          irq_n;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 0;
    exp_t sb_q[$];
    event chk_ev;

    always #4 clk = ~clk;

    pbirq_latch u_dut (
        .clk(clk), .rst_n(rst_n), .btn_n(btn_n),
        .clr_wr_en(clr_wr_en), .clr_wr_data(clr_wr_data),
        .status(status), .irq_n(irq_n)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver side: push an expected item and wake the monitor.
    task automatic expect_now(input string tag, input logic [7:0] st, input logic irq);
        exp_t e;
        e.tag = tag; e.st = st; e.irq = irq;
        sb_q.push_back(e);
        -> chk_ev;
        #1;
    endtask

    task automatic host_clear(input logic [NB-1:0] bits);
        clr_wr_en = 1'b1; clr_wr_data = bits;
        tick(1);
        clr_wr_en = 1'b0;
    endtask

    // Monitor: pop expected items and compare with the outputs.
    initial begin
        forever begin
            @(chk_ev);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_checks++;
                if (status !== e.st || irq_n !== e.irq) begin
                    n_errors++;
                    $display("FAIL %s: status=%h irq_n=%b expected status=%h irq_n=%b",
                             e.tag, status, irq_n, e.st, e.irq);
                end
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        expect_now("R1 reset held", 8'hF0, 1'b1);
        rst_n = 1'b1;
        tick(2);
        expect_now("R1 after reset", 8'hF0, 1'b1);
        expect_now("R8 low nibble zero", 8'hF0, 1'b1);

        // R2: press button 0, flag after three edges, not before
        btn_n[0] = 1'b0;
        tick(2);
        expect_now("R2 sync latency", 8'hF0, 1'b1);
        tick(1);
        expect_now("R2 press latches / R6 irq low", 8'hE0, 1'b0);

        // R4: clear while held; R3 held button stays clear
        host_clear(4'b0001);
        tick(1);
        expect_now("R4 clear releases flag", 8'hF0, 1'b1);
        // R5: re-press while clear held is ignored
        btn_n[0] = 1'b1; tick(4);
        btn_n[0] = 1'b0; tick(4);
        expect_now("R5 press under clear ignored", 8'hF0, 1'b1);
        host_clear(4'b0000);
        tick(5);
        expect_now("R3 held button no re-flag", 8'hF0, 1'b1);

        // R2: release edge sets nothing
        btn_n[0] = 1'b1; tick(5);
        expect_now("R2 release no flag", 8'hF0, 1'b1);

        // R7: two presses, partial clear keeps irq low
        btn_n[1] = 1'b0; tick(3);
        expect_now("R7 first press", 8'hD0, 1'b0);
        btn_n[2] = 1'b0; tick(3);
        expect_now("R7 second press latched", 8'h90, 1'b0);
        host_clear(4'b0010);
        tick(1);
        expect_now("R7 partial clear irq stays low", 8'hB0, 1'b0);
        host_clear(4'b0000);
        host_clear(4'b0100);
        tick(1);
        expect_now("R6 last clear releases irq", 8'hF0, 1'b1);
        host_clear(4'b0000);
        btn_n[1] = 1'b1; btn_n[2] = 1'b1; tick(4);

        // R5: simultaneous presses, clear held on button 3 only
        host_clear(4'b1000);
        btn_n[3] = 1'b0; btn_n[0] = 1'b0; tick(3);
        expect_now("R5 same-cycle press vs clear", 8'hE0, 1'b0);
        host_clear(4'b0001);
        tick(1);
        expect_now("R4 clear with other bit dropped", 8'hF0, 1'b1);
        host_clear(4'b0000);
        btn_n = '1; tick(4);

        // R7: all four at once
        btn_n = 4'b0000; tick(3);
        expect_now("R7 all flags pending", 8'h00, 1'b0);
        host_clear(4'b1111);
        tick(1);
        expect_now("R4 all cleared", 8'hF0, 1'b1);
        host_clear(4'b0000);
        tick(2);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule